// File: doc/BRIEF.md
# Flag-Conditioned Writeback Unit

This unit is the last stage of a small 16-bit processor with eight general registers. Each cycle in which `wb_valid` is high it receives one result word, together with a 6-bit condition code, a choice between a register and the program counter as target, a register index and one write enable per byte lane. It compares the stored zero and carry flags with the condition code. If the comparison passes, the result is committed. If it fails, the result is dropped and the program counter steps to the next instruction.

The unit holds the register file, the program counter and the two flag bits. The register file has two registered read ports. The flags are loaded through a separate flag port, and a condition is always judged against the flag values held before the current clock edge. Branches, jumps, conditional moves and plain register writes therefore all share one commit path.

Top module: `wb_unit`

## Requirements
- R1: A synchronous active-high reset sets the program counter, all eight registers, both stored flags and both read-port outputs to zero.
- R2: The condition code is {enable (bit 5), zero test (bits 4:3), combine (bit 2), carry test (bits 1:0)}. Each 2-bit test is satisfied as follows: code 00 when the flag is 0, code 01 when the flag is 1, and codes 10 and 11 are don't-care.
- R3: With combine = 1 the condition holds only if both tests are satisfied, a don't-care test counting as satisfied. With combine = 0 the condition holds if both tests are don't-care, or if at least one test that is not don't-care is met.
- R4: With enable (bit 5) = 0 the condition never holds, whatever the flags. Code 6'b000000 therefore blocks the write, and code 6'b110010 always commits.
- R5: When the condition holds and `wb_to_pc` = 1, the program counter takes `wb_data` at the next edge and no register changes.
- R6: When the condition holds and `wb_to_pc` = 0, register `wb_idx` is written. Lane bit 1 controls bits 15:8 and lane bit 0 controls bits 7:0. A lane whose bit is 0 keeps its value, and no other register changes.
- R7: On a valid cycle that does not load the program counter (condition fails, or the target is a register), the program counter increases by 2.
- R8: When `flag_we` = 1, the stored flags take `flag_z_in` and `flag_c_in` at the edge. A condition evaluated in that same cycle uses the flags held before that edge.
- R9: Each read port returns, one cycle after its index is presented, the register contents from before any write at the same edge.
- R10: With `wb_valid` = 0, neither the program counter nor any register changes, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | A writeback is presented this cycle |
| wb_data | input | 16 | Result word to commit |
| wb_cond | input | 6 | Condition code |
| wb_to_pc | input | 1 | 1: target is the program counter, 0: target is a register |
| wb_idx | input | 3 | Target register index |
| wb_lane_we | input | 2 | Byte lane enables, bit 1 = high byte, bit 0 = low byte |
| flag_we | input | 1 | Load the stored flags |
| flag_z_in | input | 1 | New zero flag |
| flag_c_in | input | 1 | New carry flag |
| rd_a_idx | input | 3 | Read port A index |
| rd_b_idx | input | 3 | Read port B index |
| rd_a_data | output | 16 | Read port A data, registered |
| rd_b_data | output | 16 | Read port B data, registered |
| pc_q | output | 16 | Program counter |

## Verification
Two events can fall in the same cycle. A flag load can coincide with a conditional commit, and a register write can coincide with a read of the same register. The bench provokes the first by loading flags that would flip an equal test while that test is being judged. It provokes the second by pointing a read port at the register being written. In both cases the reference model, updated in program order, expects the old flags and the old register contents. A sweep of all 64 condition codes under all four flag combinations, for both target kinds, judges the compact condition encoding.

// File: rtl/wb_pkg.sv
package wb_pkg;

  typedef struct packed {
    logic       en;
    logic [1:0] z_t;
    logic       comb;
    logic [1:0] c_t;
  } cond_t;

  localparam int COND_W = $bits(cond_t);

  localparam logic [COND_W-1:0] COND_ALWAYS = 6'b110010;
  localparam logic [COND_W-1:0] COND_NEVER  = 6'b000000;

endpackage

// File: rtl/wb_cond_eval.sv
module wb_cond_eval
  import wb_pkg::*;
(
  input  cond_t cw,
  input  logic  z_q,
  input  logic  c_q,
  output logic  pass
);

  logic z_dc, c_dc;
  logic z_hit, c_hit;
  logic z_strict, c_strict;
  logic test;

  always_comb begin
    z_dc     = cw.z_t[1];
    c_dc     = cw.c_t[1];
    z_strict = !z_dc && (z_q == cw.z_t[0]);
    c_strict = !c_dc && (c_q == cw.c_t[0]);
    z_hit    = z_dc || z_strict;
    c_hit    = c_dc || c_strict;
    if (cw.comb) test = z_hit && c_hit;
    else         test = (z_dc && c_dc) || z_strict || c_strict;
    pass = cw.en && test;
  end

endmodule

// File: rtl/wb_flags.sv
module wb_flags (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic z_in,
  input  logic c_in,
  output logic z_q,
  output logic c_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (ld) begin
      z_q <= z_in;
      c_q <= c_in;
    end
  end

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable({z_q, c_q}));

endmodule

// File: rtl/wb_regfile.sv
module wb_regfile #(
  parameter  int DATA_W  = 16,
  parameter  int REG_CNT = 8,
  parameter  int LANE_W  = 8,
  localparam int IDX_W   = $clog2(REG_CNT),
  localparam int LANES   = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);

  logic [DATA_W-1:0] mem [REG_CNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < REG_CNT; r++) mem[r] <= '0;
    end else if (we) begin
      for (int l = 0; l < LANES; l++)
        if (lane_we[l]) mem[wr_idx][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_data <= '0;
      rb_data <= '0;
    end else begin
      ra_data <= mem[ra_idx];
      rb_data <= mem[rb_idx];
    end
  end

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg_chk
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    // R6
    reg_untouched_chk: assert property (@(posedge clk) disable iff (rst)
      !(we && wr_idx == MY_IDX) |=> $stable(mem[i]));
    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      // R6
      lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wr_idx == MY_IDX && !lane_we[l]) |=> $stable(mem[i][l*LANE_W +: LANE_W]));
    end
  end

endmodule

// File: rtl/wb_pc.sv
module wb_pc #(
  parameter int DATA_W  = 16,
  parameter int PC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] pc_q
);

  localparam logic [DATA_W-1:0] INC = DATA_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (step) pc_q <= load ? load_val : pc_q + INC;
  end

  // R7
  pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> pc_q == $past(pc_q) + INC);

  // R10
  pc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pc_q));

endmodule

// File: rtl/wb_unit.sv
module wb_unit
  import wb_pkg::*;
#(
  parameter  int DATA_W  = 16,
  parameter  int REG_CNT = 8,
  parameter  int LANE_W  = 8,
  parameter  int PC_STEP = 2,
  localparam int IDX_W   = $clog2(REG_CNT),
  localparam int LANES   = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_valid,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [COND_W-1:0] wb_cond,
  input  logic              wb_to_pc,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [LANES-1:0]  wb_lane_we,
  input  logic              flag_we,
  input  logic              flag_z_in,
  input  logic              flag_c_in,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [DATA_W-1:0] pc_q
);

  cond_t cw;
  logic  z_q, c_q;
  logic  take;
  logic  pc_load, reg_we;

  assign cw      = cond_t'(wb_cond);
  assign pc_load = take && wb_to_pc;
  assign reg_we  = wb_valid && take && !wb_to_pc;

  wb_flags u_flags (
    .clk  (clk),
    .rst  (rst),
    .ld   (flag_we),
    .z_in (flag_z_in),
    .c_in (flag_c_in),
    .z_q  (z_q),
    .c_q  (c_q)
  );

  wb_cond_eval u_cond (
    .cw   (cw),
    .z_q  (z_q),
    .c_q  (c_q),
    .pass (take)
  );

  wb_regfile #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT),
    .LANE_W  (LANE_W)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .wr_idx  (wb_idx),
    .lane_we (wb_lane_we),
    .wr_data (wb_data),
    .ra_idx  (rd_a_idx),
    .rb_idx  (rd_b_idx),
    .ra_data (rd_a_data),
    .rb_data (rd_b_data)
  );

  wb_pc #(
    .DATA_W  (DATA_W),
    .PC_STEP (PC_STEP)
  ) u_pc (
    .clk      (clk),
    .rst      (rst),
    .step     (wb_valid),
    .load     (pc_load),
    .load_val (wb_data),
    .pc_q     (pc_q)
  );

  // R5
  pc_take_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_to_pc && take) |=> pc_q == $past(wb_data));

  // R4
  cond_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_cond[COND_W-1]) |=> pc_q == $past(pc_q) + DATA_W'(PC_STEP));

endmodule

// File: tb/wb_unit_test.sv
module wb_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        wb_valid;
  logic [15:0] wb_data;
  logic [5:0]  wb_cond;
  logic        wb_to_pc;
  logic [2:0]  wb_idx;
  logic [1:0]  wb_lane_we;
  logic        flag_we, flag_z_in, flag_c_in;
  logic [2:0]  rd_a_idx, rd_b_idx;
  logic [15:0] rd_a_data, rd_b_data, pc_q;

  always #5 clk = ~clk;

  wb_unit uut (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_data(wb_data),
    .wb_cond(wb_cond), .wb_to_pc(wb_to_pc), .wb_idx(wb_idx),
    .wb_lane_we(wb_lane_we), .flag_we(flag_we), .flag_z_in(flag_z_in),
    .flag_c_in(flag_c_in), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .pc_q(pc_q)
  );

  logic [15:0] m_reg [8];
  logic [15:0] m_pc, e_ra, e_rb;
  logic        m_z, m_c;
  int          checks = 0;
  int          fails  = 0;
  string       req_tag = "R1";

  // Reference condition test, written from the requirement text
  function automatic bit ref_ok(logic [5:0] cw, logic z, logic c);
    bit zdc, cdc, zm, cm;
    if (cw[5] == 1'b0) return 0;
    zdc = cw[4];
    cdc = cw[1];
    zm  = (cw[4:3] == 2'b00 && z == 0) || (cw[4:3] == 2'b01 && z == 1);
    cm  = (cw[1:0] == 2'b00 && c == 0) || (cw[1:0] == 2'b01 && c == 1);
    if (cw[2]) return (zdc || zm) && (cdc || cm);
    return (zdc && cdc) || zm || cm;
  endfunction

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [15:0] mask;
    if (rst) begin
      foreach (m_reg[i]) m_reg[i] = 16'h0;
      m_pc = 0; e_ra = 0; e_rb = 0; m_z = 0; m_c = 0;
    end else begin
      e_ra = m_reg[rd_a_idx];
      e_rb = m_reg[rd_b_idx];
      if (wb_valid) begin
        if (ref_ok(wb_cond, m_z, m_c) && wb_to_pc) m_pc = wb_data;
        else begin
          m_pc = m_pc + 16'd2;
          if (ref_ok(wb_cond, m_z, m_c)) begin
            mask = {{8{wb_lane_we[1]}}, {8{wb_lane_we[0]}}};
            m_reg[wb_idx] = (m_reg[wb_idx] & ~mask) | (wb_data & mask);
          end
        end
      end
      if (flag_we) begin m_z = flag_z_in; m_c = flag_c_in; end
    end
    @(negedge clk);
    chk("pc", pc_q, m_pc);
    chk("read A", rd_a_data, e_ra);
    chk("read B", rd_b_data, e_rb);
  endtask

  task automatic drive(input logic v, input logic [15:0] d, input logic [5:0] cw,
                       input logic tp, input logic [2:0] idx, input logic [1:0] ln,
                       input logic fw, input logic fz, input logic fc,
                       input logic [2:0] ra, input logic [2:0] rb);
    wb_valid = v; wb_data = d; wb_cond = cw; wb_to_pc = tp; wb_idx = idx;
    wb_lane_we = ln; flag_we = fw; flag_z_in = fz; flag_c_in = fc;
    rd_a_idx = ra; rd_b_idx = rb;
    tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 reset state
    req_tag = "R1";
    repeat (2) tick();
    rst = 1'b0;
    for (int i = 0; i < 9; i++) drive(0, 16'hFFFF, 6'b110010, 0, 3'(i), 2'b11, 0, 0, 0, 3'(i), 3'(7 - i));

    // R6 byte lanes
    req_tag = "R6";
    for (int i = 0; i < 8; i++) drive(1, 16'h1111 * 16'(i + 1), 6'b110010, 0, 3'(i), 2'b11, 0, 0, 0, 3'(i - 1), 0);
    drive(1, 16'hABCD, 6'b110010, 0, 3, 2'b10, 0, 0, 0, 7, 0);
    drive(1, 16'h1234, 6'b110010, 0, 5, 2'b01, 0, 0, 0, 3, 0);
    drive(1, 16'h9999, 6'b110010, 0, 6, 2'b00, 0, 0, 0, 5, 6);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 6, 3);

    // R2 R3 R4 R5 R7 sweep of all codes and flag values
    req_tag = "R2 R3 R4 R5 R6 R7";
    for (int f = 0; f < 4; f++) begin
      drive(0, 0, 0, 0, 0, 0, 1, f[1], f[0], 0, 0);
      for (int p = 0; p < 2; p++)
        for (int cw = 0; cw < 64; cw++)
          drive(1, 16'h4001 + 16'(cw << 4) + 16'(f << 10), 6'(cw), p == 0, 3'(cw), 2'b11,
                0, 0, 0, 3'(cw - 1), 3'(cw));
    end

    // R8 flag load in the same cycle as a conditional branch
    req_tag = "R8";
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);          // Z=1 C=0
    drive(1, 16'h2220, 6'b101100, 1, 0, 0, 1, 0, 1, 0, 0); // eq uses old flags, taken
    drive(1, 16'h3330, 6'b101100, 1, 0, 0, 0, 0, 0, 0, 0); // eq now fails
    drive(1, 16'h4440, 6'b100101, 1, 0, 0, 0, 0, 0, 0, 0); // lt taken with Z=0 C=1

    // R9 read and write of the same register at one edge
    req_tag = "R9";
    drive(1, 16'hBEEF, 6'b110010, 0, 2, 2'b11, 0, 0, 0, 2, 2);
    drive(1, 16'hCAFE, 6'b110010, 0, 2, 2'b01, 0, 0, 0, 2, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 2);

    // R10 idle cycles ignore everything else
    req_tag = "R10";
    drive(0, 16'h7770, 6'b110010, 1, 2, 2'b11, 0, 0, 0, 2, 2);
    drive(0, 16'h6660, 6'b110010, 0, 2, 2'b11, 0, 0, 0, 2, 2);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 2);

    // Mixed traffic
    req_tag = "R5 R6 R7 R8 R9 R10";
    for (int n = 0; n < 600; n++) begin
      logic [5:0] cw;
      case ($urandom % 8)
        0: cw = 6'b101100; 1: cw = 6'b100110; 2: cw = 6'b100100;
        3: cw = 6'b101000; 4: cw = 6'b100101; 5: cw = 6'b101001;
        6: cw = 6'b110010; default: cw = 6'($urandom);
      endcase
      drive(($urandom % 5) != 0, 16'($urandom), cw, ($urandom % 4) == 0, 3'($urandom),
            2'($urandom), ($urandom % 3) == 0, 1'($urandom), 1'($urandom),
            3'($urandom), 3'($urandom));
    end

    // R1 reset after traffic
    req_tag = "R1";
    rst = 1'b1;
    drive(1, 16'h5555, 6'b110010, 0, 1, 2'b11, 1, 1, 1, 0, 0);
    rst = 1'b0;
    for (int i = 0; i < 9; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'(i), 3'(i + 4));
    drive(1, 16'h1000, 6'b101100, 1, 0, 0, 0, 0, 0, 0, 0); // eq fails on cleared flags

    finish_run();
  end

endmodule